// File: doc/BRIEF.md
# Multi-Mode Triggered Sample FIFO

This block buffers sensor sample words between a producer and a register-style reader. A control write loads a 3-bit mode code, a 5-bit threshold and a stop-at-threshold flag. The mode decides what happens to incoming samples. In the off behaviour nothing is stored. In the stop-when-full behaviour samples are dropped once the buffer is full. In the overwrite behaviour a sample that arrives when the buffer is full replaces the oldest stored entry. Three of the codes start in one behaviour and move to another when the trigger input falls. The trigger comes from an external event detector.

A small state machine holds the current behaviour. Its states are S_OFF, S_KEEP (stop-when-full), S_ROLL (overwrite-oldest), S_ROLL_TO_KEEP, S_OFF_TO_ROLL and S_OFF_TO_KEEP. A control write moves the machine straight into the start state for the new code. The transitions ROLL_TO_KEEP→KEEP, OFF_TO_ROLL→ROLL and OFF_TO_KEEP→KEEP happen on a falling edge of the trigger. A trigger falling edge is one sampled cycle with the trigger high followed by one with it low.

Status outputs give the fill level, a threshold flag, a full (overrun) flag and an empty flag. A read pops the oldest entry onto `rd_data` one cycle later.

Top module: `trig_sample_fifo`

## Requirements
- R1: After reset the mode is off (code 000), the threshold is 0, the stop flag is clear, the level is 0, `st_empty`=1, `st_ovr`=0, `st_thr`=1 and `rd_data`=0.
- R2: Code 000, and the unused codes 101 and 110, select S_OFF. In S_OFF the incoming samples are discarded and the level stays at 0.
- R3: Code 001 selects S_KEEP. When the level equals the effective depth, a new sample is dropped and the stored entries are kept unchanged.
- R4: Code 010 selects S_ROLL. When the buffer is full, a new sample is stored, the oldest entry is discarded and the level stays the same.
- R5: Code 011 starts in S_ROLL_TO_KEEP, which behaves like S_ROLL. On a trigger falling edge it moves to S_KEEP and keeps its stored data.
- R6: Code 100 starts in S_OFF_TO_ROLL, which discards samples. On a trigger falling edge it moves to S_ROLL.
- R7: Code 111 starts in S_OFF_TO_KEEP, which discards samples. On a trigger falling edge it moves to S_KEEP.
- R8: A control write (`cfg_wr`=1) empties the buffer and resets the pointers. A sample or read presented in the same cycle is ignored, and `rd_data` keeps its value.
- R9: When the buffer is not empty, a read pops the oldest entry and places it on `rd_data` in the next cycle. A read of an empty buffer leaves `rd_data` and the level unchanged.
- R10: `st_thr` is 1 exactly when the level is greater than or equal to the threshold.
- R11: `st_ovr` is 1 when the level has reached the effective depth. `st_empty` is 1 when the level is 0.
- R12: The effective depth is the threshold when the stop flag is set and the threshold is nonzero. Otherwise it is the physical depth of 32.
- R13: `st_level` is 6 bits wide and reports every count from 0 to 32, including a full count of 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_mode | input | 3 | Mode code |
| cfg_thr | input | 5 | Threshold |
| cfg_stop | input | 1 | Use the threshold as the effective depth |
| trig | input | 1 | Trigger from the event detector |
| smp_valid | input | 1 | Sample present |
| smp_data | input | DW | Sample word |
| rd_en | input | 1 | Read (pop) strobe |
| rd_data | output | DW | Popped sample, registered |
| st_thr | output | 1 | Level at or above the threshold |
| st_ovr | output | 1 | Buffer full at the effective depth |
| st_empty | output | 1 | No samples stored |
| st_level | output | 6 | Stored sample count |

## Verification
A wrong behaviour state becomes visible within one sample. A sample accepted in an off state raises `st_level` at the next edge. A stop state that overwrites shows up on the next pop, which returns a newer word than expected. If the trigger-edge tracking is wrong, the first sample after the falling edge lands in the wrong behaviour. Pointer or count corruption shows up as a wrong popped word or level one cycle after the read.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    typedef enum logic [2:0] {
        MODE_OFF        = 3'b000,
        MODE_KEEP       = 3'b001,
        MODE_ROLL       = 3'b010,
        MODE_ROLL_KEEP  = 3'b011,
        MODE_OFF_ROLL   = 3'b100,
        MODE_OFF_KEEP   = 3'b111
    } mode_e;

    typedef enum logic [2:0] {
        S_OFF,
        S_KEEP,
        S_ROLL,
        S_ROLL_TO_KEEP,
        S_OFF_TO_ROLL,
        S_OFF_TO_KEEP
    } state_t;

endpackage

// File: rtl/sfifo_mode_fsm.sv
module sfifo_mode_fsm
    import sfifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [2:0] cfg_mode,
    input  logic       trig,
    output logic       accept,
    output logic       overwrite
);

    state_t state_q, state_d;
    logic   trig_q;
    logic   trig_fall;

    assign trig_fall = trig_q & ~trig;

    function automatic state_t start_state(input logic [2:0] code);
        state_t s;
        unique case (code)
            MODE_KEEP:      s = S_KEEP;
            MODE_ROLL:      s = S_ROLL;
            MODE_ROLL_KEEP: s = S_ROLL_TO_KEEP;
            MODE_OFF_ROLL:  s = S_OFF_TO_ROLL;
            MODE_OFF_KEEP:  s = S_OFF_TO_KEEP;
            default:        s = S_OFF;
        endcase
        return s;
    endfunction

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cfg_wr) begin
            state_d = start_state(cfg_mode);
        end else if (trig_fall) begin
            unique case (state_q)
                S_ROLL_TO_KEEP: state_d = S_KEEP;
                S_OFF_TO_ROLL:  state_d = S_ROLL;
                S_OFF_TO_KEEP:  state_d = S_KEEP;
                default:        state_d = state_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            trig_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            trig_q  <= trig;
        end
    end

    // outputs
    always_comb begin
        accept    = 1'b0;
        overwrite = 1'b0;
        unique case (state_q)
            S_KEEP:         accept = 1'b1;
            S_ROLL,
            S_ROLL_TO_KEEP: begin
                accept    = 1'b1;
                overwrite = 1'b1;
            end
            default: begin
                accept    = 1'b0;
                overwrite = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          accept,
    input  logic          overwrite,
    input  logic [CW-1:0] eff_depth,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt_after_pop;
    logic          pop, room, push, drop;

    assign pop           = rd_en && (count != '0);
    assign cnt_after_pop = count - CW'(pop);
    assign room          = cnt_after_pop < eff_depth;
    assign push          = smp_valid && accept && (room || overwrite);
    assign drop          = smp_valid && accept && !room && overwrite;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            rd_data <= '0;
        end else if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr + AW'(1);
            rptr  <= rptr + AW'(pop) + AW'(drop);
            count <= count - CW'(pop) - CW'(drop) + CW'(push);
            if (pop) rd_data <= mem[rptr];
        end
    end

    always_ff @(posedge clk) begin
        if (!clr && push) mem[wptr] <= smp_data;
    end

endmodule

// File: rtl/trig_sample_fifo.sv
module trig_sample_fifo #(
    parameter int DEPTH = 32,
    parameter int DW    = 16,
    parameter int TW    = 5,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [2:0]    cfg_mode,
    input  logic [TW-1:0] cfg_thr,
    input  logic          cfg_stop,
    input  logic          trig,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          st_thr,
    output logic          st_ovr,
    output logic          st_empty,
    output logic [CW-1:0] st_level
);

    logic [TW-1:0] thr_q;
    logic          stop_q;
    logic [CW-1:0] eff_depth;
    logic          fsm_accept, fsm_ovw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q  <= '0;
            stop_q <= 1'b0;
        end else if (cfg_wr) begin
            thr_q  <= cfg_thr;
            stop_q <= cfg_stop;
        end
    end

    assign eff_depth = (stop_q && thr_q != '0) ? CW'(thr_q) : CW'(DEPTH);

    sfifo_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_mode  (cfg_mode),
        .trig      (trig),
        .accept    (fsm_accept),
        .overwrite (fsm_ovw)
    );

    sfifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cfg_wr),
        .accept    (fsm_accept),
        .overwrite (fsm_ovw),
        .eff_depth (eff_depth),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .count     (st_level)
    );

    assign st_empty = (st_level == '0);
    assign st_ovr   = (st_level >= eff_depth);
    assign st_thr   = (st_level >= CW'(thr_q));

endmodule

// File: rtl/sfifo_checker.sv
module sfifo_checker #(
    parameter int DEPTH = 32,
    parameter int DW    = 16,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_wr,
    input logic          smp_valid,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic          st_empty,
    input logic          st_ovr,
    input logic [CW-1:0] st_level,
    input logic          accept,
    input logic          overwrite
);

    p_level_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
        st_level <= CW'(DEPTH));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (st_empty && st_level == '0));

    p_off_no_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !cfg_wr && !rd_en) |=> $stable(st_level));

    p_keep_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !overwrite && st_ovr && !rd_en && !cfg_wr) |=> $stable(st_level));

    p_roll_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (overwrite && st_ovr && smp_valid && !rd_en && !cfg_wr) |=> st_ovr);

    p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_empty && rd_en && !cfg_wr) |=> $stable(rd_data));

    p_pop_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_empty && rd_en && !smp_valid && !cfg_wr)
        |=> (st_level == $past(st_level) - CW'(1)));

endmodule

bind trig_sample_fifo sfifo_checker #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .smp_valid (smp_valid),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .st_empty  (st_empty),
    .st_ovr    (st_ovr),
    .st_level  (st_level),
    .accept    (fsm_accept),
    .overwrite (fsm_ovw)
);

// File: tb/test_trig_sample_fifo.sv
module test_trig_sample_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_mode = '0;
    logic [4:0] cfg_thr = '0;
    logic       cfg_stop = 1'b0;
    logic       trig = 1'b0;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       st_thr, st_ovr, st_empty;
    logic [5:0] st_level;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;  // 50 MHz

    trig_sample_fifo #(.DEPTH(32), .DW(8), .TW(5)) i_trig_sample_fifo (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_thr(cfg_thr), .cfg_stop(cfg_stop), .trig(trig),
        .smp_valid(smp_valid), .smp_data(smp_data), .rd_en(rd_en),
        .rd_data(rd_data), .st_thr(st_thr), .st_ovr(st_ovr),
        .st_empty(st_empty), .st_level(st_level)
    );

    // {op(1=pop), data, expected level, expected rd_data}; mode 010, thr 4, stop 1
    localparam logic [22:0] VEC [10] = '{
        {1'b0, 8'd1, 6'd1, 8'd0}, {1'b0, 8'd2, 6'd2, 8'd0},
        {1'b0, 8'd3, 6'd3, 8'd0}, {1'b0, 8'd4, 6'd4, 8'd0},
        {1'b0, 8'd5, 6'd4, 8'd0}, {1'b0, 8'd6, 6'd4, 8'd0},
        {1'b1, 8'd0, 6'd3, 8'd3}, {1'b1, 8'd0, 6'd2, 8'd4},
        {1'b1, 8'd0, 6'd1, 8'd5}, {1'b1, 8'd0, 6'd0, 8'd6}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic cfg(input logic [2:0] m, input logic [4:0] t, input logic s);
        cfg_wr = 1'b1; cfg_mode = m; cfg_thr = t; cfg_stop = s;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic push(input logic [7:0] d);
        smp_valid = 1'b1; smp_data = d;
        tick();
        smp_valid = 1'b0;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 level", int'(st_level), 0);
        check("R1 empty", int'(st_empty), 1);
        check("R1 ovr", int'(st_ovr), 0);
        check("R1 thr", int'(st_thr), 1);
        check("R1 rd_data", int'(rd_data), 0);

        // R2 off after reset and with unused codes
        push(8'h11); push(8'h12);
        check("R2 off level", int'(st_level), 0);
        cfg(3'b101, 5'd0, 1'b0); push(8'h13);
        check("R2 code101 level", int'(st_level), 0);
        cfg(3'b110, 5'd0, 1'b0); push(8'h14);
        check("R2 code110 level", int'(st_level), 0);

        // R4 R12 vector walk in overwrite mode with depth 4
        cfg(3'b010, 5'd4, 1'b1);
        for (int i = 0; i < 10; i++) begin
            if (VEC[i][22]) pop(); else push(VEC[i][21:14]);
            check($sformatf("R4 R12 vec%0d level", i), int'(st_level), int'(VEC[i][13:8]));
            if (VEC[i][22])
                check($sformatf("R4 vec%0d rd", i), int'(rd_data), int'(VEC[i][7:0]));
        end

        // R3 R11 R13 stop-when-full at physical depth
        cfg(3'b001, 5'd0, 1'b0);
        for (int i = 0; i < 35; i++) push(8'(i));
        check("R13 full level", int'(st_level), 32);
        check("R11 ovr full", int'(st_ovr), 1);
        check("R11 not empty", int'(st_empty), 0);
        pop();
        check("R3 oldest kept", int'(rd_data), 0);
        check("R3 level after pop", int'(st_level), 31);
        check("R11 ovr cleared", int'(st_ovr), 0);

        // R10 threshold flag
        cfg(3'b001, 5'd3, 1'b0);
        push(8'h21); push(8'h22);
        check("R10 below thr", int'(st_thr), 0);
        push(8'h23);
        check("R10 at thr", int'(st_thr), 1);

        // R12 stop flag limits depth
        cfg(3'b001, 5'd3, 1'b1);
        for (int i = 0; i < 5; i++) push(8'(8'h30 + i));
        check("R12 level", int'(st_level), 3);
        check("R12 ovr", int'(st_ovr), 1);
        pop();
        check("R12 rd oldest", int'(rd_data), 8'h30);

        // R5 overwrite then stop on trigger fall
        trig = 1'b1; tick();
        cfg(3'b011, 5'd2, 1'b1);
        push(8'h40); push(8'h41); push(8'h42);
        check("R5 roll level", int'(st_level), 2);
        trig = 1'b0; tick();
        push(8'h43);
        check("R5 keep level", int'(st_level), 2);
        pop();
        check("R5 data kept", int'(rd_data), 8'h41);

        // R6 off then overwrite
        trig = 1'b1; tick();
        cfg(3'b100, 5'd2, 1'b1);
        push(8'h50);
        check("R6 off level", int'(st_level), 0);
        trig = 1'b0; tick();
        push(8'h51); push(8'h52); push(8'h53);
        check("R6 roll level", int'(st_level), 2);
        pop();
        check("R6 rd", int'(rd_data), 8'h52);

        // R7 off then stop-when-full
        trig = 1'b1; tick();
        cfg(3'b111, 5'd2, 1'b1);
        push(8'h60);
        check("R7 off level", int'(st_level), 0);
        trig = 1'b0; tick();
        push(8'h61); push(8'h62); push(8'h63);
        check("R7 keep level", int'(st_level), 2);
        pop();
        check("R7 rd", int'(rd_data), 8'h61);

        // R8 control write clears, same-cycle sample/read ignored
        cfg(3'b001, 5'd0, 1'b0);
        push(8'h70); push(8'h71);
        cfg_wr = 1'b1; cfg_mode = 3'b001; smp_valid = 1'b1; smp_data = 8'h72; rd_en = 1'b1;
        tick();
        cfg_wr = 1'b0; smp_valid = 1'b0; rd_en = 1'b0;
        check("R8 level", int'(st_level), 0);
        check("R8 empty", int'(st_empty), 1);
        check("R8 rd unchanged", int'(rd_data), 8'h61);

        // R9 pop order and empty read
        push(8'h80); push(8'h81);
        pop();
        check("R9 pop first", int'(rd_data), 8'h80);
        pop();
        check("R9 pop second", int'(rd_data), 8'h81);
        pop();
        check("R9 empty read rd", int'(rd_data), 8'h81);
        check("R9 empty read level", int'(st_level), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule